// File: doc/BRIEF.md
# SRAM Built-In Self-Test Engine

This block runs a fixed self-test on a byte-wide synchronous SRAM of 2^ADDR_W locations. It owns the memory's address, write data, write enable and read enable, and consumes the read data, which the memory returns one cycle after a read is requested. A single start pulse launches four phases in a set order: a walking-ones check of the data lines at location 0, a check of every address line using the power-of-two locations, a full check that every bit of every location holds both 0 and 1, and a closing checksum over the whole array.

The device test leaves every location at zero, so the checksum over the array must come out as zero. The run stops at the first phase that finds a fault. The block then raises `done` with `pass` low, and holds the phase number and a value describing the failure until the next start. A clean run raises `done` and `pass` together. ADDR_W must be at least 3.

Top module: `sram_bist`

## Requirements
- R1: During and right after reset: `done`=0, `pass`=0, `fail_phase`=0, `fail_value`=0, `mem_we`=0 and `mem_re`=0.
- R2: While idle the block makes no memory access. A `start` that arrives while a run is in progress is ignored: `done` stays low and the run's result is unchanged.
- R3: Phase 0 (data lines) writes each of 01h, 02h, 04h through 80h to location 0 and reads each one back before writing the next. On the first mismatch it reports `fail_phase`=0 and `fail_value` equal to the written pattern, which is never zero.
- R4: Phase 1 (address lines) uses the list made of location 0 followed by 1, 2, 4 up to 2^(ADDR_W-1).
  - It first writes AAh to every entry of the list.
  - Then, for each entry in list order, it writes 55h to that entry and reads every other entry in list order, expecting AAh. It then restores AAh to the entry.
  - On the first mismatch it reports `fail_phase`=1 and `fail_value` equal to the address that read back wrong.
- R5: Phase 2 (device) runs five passes, each in ascending address order:
  - write P(a) = (low byte of a) + 1 to every location;
  - read every location back and check it against P(a);
  - write ~P(a) to every location;
  - read every location back and check it against ~P(a);
  - write 00h to every location.
  - On the first mismatch it reports `fail_phase`=2 and `fail_value` equal to the failing address.
- R6: After a passing run, every location of the memory holds 00h.
- R7: Phase 3 (checksum) reads every location in ascending order and adds the bytes modulo 256. A nonzero sum reports `fail_phase`=3 and `fail_value` equal to the sum.
- R8: A passing run ends with `done`=1, `pass`=1, `fail_phase`=0 and `fail_value`=0. Once `done` rises, all result outputs hold steady until the next `start`, and a `start` given after `done` begins a new run and clears `done` on the following clock edge.
- R9: `mem_we` and `mem_re` are never high together, and the cycle after a read request makes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read request; data returns next cycle |
| mem_rdata | input | 8 | Memory read data |
| done | output | 1 | Run finished (held until next start) |
| pass | output | 1 | All phases succeeded |
| fail_phase | output | 2 | Failing phase: 0 data lines, 1 address lines, 2 device, 3 checksum |
| fail_value | output | max(ADDR_W,8) | Failing pattern, address or checksum |

## Verification
The bench builds the block with ADDR_W=6, so a run over the 64-location array takes well under a thousand cycles. That keeps dozens of complete runs affordable, and every location can be covered by an injected fault. The bench memory model can inject several kinds of fault:
- a stuck data bit at one location, which at location 0 trips phase 0 and elsewhere trips phase 1 or 2;
- a shorted address line, which trips phase 1;
- a location that ignores zero writes, which survives the device test and surfaces only in the checksum.

The expected phase and value for each run come from a transaction-level walk of the four phases over the same faulty memory.

// File: rtl/sram_bist.sv
module sram_bist #(
  parameter int ADDR_W = 10,
  localparam int VW = (ADDR_W > 8) ? ADDR_W : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_phase,
  output logic [VW-1:0]     fail_value
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NPOS = ADDR_W[ADDR_W-1:0];
  localparam logic [7:0] MARK = 8'hAA;

  typedef enum logic [3:0] {
    S_IDLE, S_DBW, S_DBR, S_DBC,
    S_ABI, S_ABV, S_ABR, S_ABC, S_ABS,
    S_DVW, S_DVR, S_DVC, S_CSR, S_CSC
  } state_t;

  state_t            st;
  logic [ADDR_W-1:0] cnt, tidx;
  logic [1:0]        dmode;
  logic [7:0]        sum;

  function automatic logic [ADDR_W-1:0] laddr(input logic [ADDR_W-1:0] j);
    return (j == '0) ? '0 : (ADDR_W'(1) << (j - 1'b1));
  endfunction

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return 8'(a) + 8'd1;
  endfunction

  logic [7:0]        walk, expd, sum_n;
  logic [ADDR_W-1:0] nx1, nxt;

  assign walk  = 8'd1 << cnt[2:0];
  assign expd  = (dmode == 2'd0) ? pat(cnt) : ~pat(cnt);
  assign sum_n = sum + mem_rdata;
  assign nx1   = cnt + 1'b1;
  assign nxt   = (nx1 == tidx) ? nx1 + 1'b1 : nx1;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = 8'h00;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    case (st)
      S_DBW: begin mem_wdata = walk; mem_we = 1'b1; end
      S_DBR: mem_re = 1'b1;
      S_ABI: begin mem_addr = laddr(cnt); mem_wdata = MARK; mem_we = 1'b1; end
      S_ABV: begin mem_addr = laddr(tidx); mem_wdata = ~MARK; mem_we = 1'b1; end
      S_ABR: begin mem_addr = laddr(cnt); mem_re = 1'b1; end
      S_ABS: begin mem_addr = laddr(tidx); mem_wdata = MARK; mem_we = 1'b1; end
      S_DVW: begin
        mem_addr  = cnt;
        mem_wdata = (dmode == 2'd2) ? 8'h00 : expd;
        mem_we    = 1'b1;
      end
      S_DVR, S_CSR: begin mem_addr = cnt; mem_re = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tidx <= '0; dmode <= '0; sum <= '0;
      done <= 1'b0; pass <= 1'b0; fail_phase <= '0; fail_value <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0; pass <= 1'b0; fail_phase <= '0; fail_value <= '0;
          cnt <= '0; st <= S_DBW;
        end
        S_DBW: st <= S_DBR;
        S_DBR: st <= S_DBC;
        S_DBC:
          if (mem_rdata != walk) begin
            st <= S_IDLE; done <= 1'b1; fail_phase <= 2'd0; fail_value <= VW'(walk);
          end else if (cnt == ADDR_W'(7)) begin
            cnt <= '0; st <= S_ABI;
          end else begin
            cnt <= cnt + 1'b1; st <= S_DBW;
          end
        S_ABI:
          if (cnt == NPOS) begin tidx <= '0; st <= S_ABV; end
          else cnt <= cnt + 1'b1;
        S_ABV: begin
          cnt <= (tidx == '0) ? ADDR_W'(1) : '0;
          st  <= S_ABR;
        end
        S_ABR: st <= S_ABC;
        S_ABC:
          if (mem_rdata != MARK) begin
            st <= S_IDLE; done <= 1'b1; fail_phase <= 2'd1; fail_value <= VW'(laddr(cnt));
          end else if (nxt > NPOS) st <= S_ABS;
          else begin cnt <= nxt; st <= S_ABR; end
        S_ABS:
          if (tidx == NPOS) begin cnt <= '0; dmode <= 2'd0; st <= S_DVW; end
          else begin tidx <= tidx + 1'b1; st <= S_ABV; end
        S_DVW:
          if (cnt == LAST) begin
            cnt <= '0;
            if (dmode == 2'd2) begin sum <= '0; st <= S_CSR; end
            else st <= S_DVR;
          end else cnt <= cnt + 1'b1;
        S_DVR: st <= S_DVC;
        S_DVC:
          if (mem_rdata != expd) begin
            st <= S_IDLE; done <= 1'b1; fail_phase <= 2'd2; fail_value <= VW'(cnt);
          end else if (cnt == LAST) begin
            cnt <= '0; dmode <= dmode + 2'd1; st <= S_DVW;
          end else begin
            cnt <= cnt + 1'b1; st <= S_DVR;
          end
        S_CSR: st <= S_CSC;
        S_CSC: begin
          sum <= sum_n;
          if (cnt == LAST) begin
            st <= S_IDLE; done <= 1'b1;
            if (sum_n != 8'h00) begin fail_phase <= 2'd3; fail_value <= VW'(sum_n); end
            else pass <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1; st <= S_CSR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));

  // R9
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_we && !mem_re);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we && !mem_re);

  // R8
  pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n) pass |-> done);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass) && $stable(fail_phase) && $stable(fail_value));

  // R3
  data_fail_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !pass && fail_phase == 2'd0 |-> fail_value != '0);

  // R4
  addr_fail_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !pass && fail_phase == 2'd1 |-> $countones(fail_value) <= 1);

  // R7
  sum_fail_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !pass && fail_phase == 2'd3 |-> fail_value != '0);

endmodule

// File: tb/sram_bist_test.sv
`timescale 1ns/1ps
module sram_bist_test;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_we, mem_re, done, pass;
  logic [1:0] fail_phase;
  logic [7:0] fail_value;

  always #2 clk = ~clk;

  sram_bist #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .pass(pass),
    .fail_phase(fail_phase), .fail_value(fail_value));

  int checks = 0, errors = 0;
  int both_cnt = 0;
  int ft = 0, fa = 0, fb = 0, fv = 0;
  logic [7:0] bmem [DEPTH];
  logic [7:0] imem [DEPTH];

  function automatic int phys(input int a);
    return (ft == 2) ? (a & ~(1 << fb)) : a;
  endfunction

  function automatic logic [7:0] frd(input int a);
    logic [7:0] d;
    int p;
    p = phys(a);
    d = bmem[p];
    if (ft == 1 && p == fa) d[fb] = fv[0];
    return d;
  endfunction

  task automatic fwr(input int a, input logic [7:0] d);
    int p;
    p = phys(a);
    if (!(ft == 3 && p == fa && d == 8'h00)) bmem[p] = d;
  endtask

  always @(posedge clk) begin
    if (mem_we && mem_re) both_cnt++;
    if (mem_re) mem_rdata <= frd(int'(mem_addr));
    if (mem_we) fwr(int'(mem_addr), mem_wdata);
  end

  function automatic int la(input int j);
    return (j == 0) ? 0 : (1 << (j - 1));
  endfunction

  function automatic logic [7:0] pt(input int a);
    return 8'(a) + 8'd1;
  endfunction

  task automatic ref_run(output logic ep, output logic [1:0] eph, output logic [7:0] ev);
    logic [7:0] s;
    ep = 1'b0; eph = 2'd0; ev = 8'h00;
    for (int i = 0; i < 8; i++) begin
      fwr(0, 8'd1 << i);
      if (frd(0) != (8'd1 << i)) begin eph = 2'd0; ev = 8'd1 << i; return; end
    end
    for (int j = 0; j <= AW; j++) fwr(la(j), 8'hAA);
    for (int t = 0; t <= AW; t++) begin
      fwr(la(t), 8'h55);
      for (int j = 0; j <= AW; j++)
        if (j != t && frd(la(j)) != 8'hAA) begin eph = 2'd1; ev = 8'(la(j)); return; end
      fwr(la(t), 8'hAA);
    end
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < DEPTH; a++) fwr(a, m == 0 ? pt(a) : ~pt(a));
      for (int a = 0; a < DEPTH; a++)
        if (frd(a) != (m == 0 ? pt(a) : ~pt(a))) begin eph = 2'd2; ev = 8'(a); return; end
    end
    for (int a = 0; a < DEPTH; a++) fwr(a, 8'h00);
    s = 8'h00;
    for (int a = 0; a < DEPTH; a++) s = s + frd(a);
    if (s != 8'h00) begin eph = 2'd3; ev = s; return; end
    ep = 1'b1;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_run(input int t, input int a, input int b, input int v, input bit poke);
    logic ep; logic [1:0] eph; logic [7:0] ev;
    string rq;
    ft = t; fa = a; fb = b; fv = v;
    for (int i = 0; i < DEPTH; i++) imem[i] = 8'($urandom);
    for (int i = 0; i < DEPTH; i++) bmem[i] = imem[i];
    ref_run(ep, eph, ev);
    for (int i = 0; i < DEPTH; i++) bmem[i] = imem[i];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R8", "done cleared by start", int'(done), 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R2", "start mid-run ignored", int'(done), 0);
    end
    while (!done) @(negedge clk);
    rq = ep ? "R8" : (eph == 2'd0 ? "R3" : eph == 2'd1 ? "R4" : eph == 2'd2 ? "R5" : "R7");
    chk(pass == ep, rq, "pass", int'(pass), int'(ep));
    chk(fail_phase == (ep ? 2'd0 : eph), rq, "fail_phase", int'(fail_phase), int'(eph));
    chk(fail_value == (ep ? 8'h00 : ev), rq, "fail_value", int'(fail_value), int'(ev));
    if (ep) begin
      int nz;
      nz = 0;
      for (int i = 0; i < DEPTH; i++) if (bmem[i] != 8'h00) nz++;
      chk(nz == 0, "R6", "nonzero locations after pass", nz, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!done && !pass && fail_phase == 2'd0 && fail_value == 8'h00, "R1", "status in reset",
        int'({done, pass, fail_phase}), 0);
    chk(!mem_we && !mem_re, "R1", "memory strobes in reset", int'({mem_we, mem_re}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_we && !mem_re && !done, "R2", "idle after reset", int'({mem_we, mem_re, done}), 0);

    do_run(0, 0, 0, 0, 1'b0);
    begin
      logic p0; logic [1:0] ph0; logic [7:0] v0;
      int acc;
      p0 = pass; ph0 = fail_phase; v0 = fail_value; acc = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (mem_we || mem_re) acc++;
      end
      chk(acc == 0, "R2", "accesses while idle", acc, 0);
      chk(pass == p0 && fail_phase == ph0 && fail_value == v0 && done, "R8", "result held",
          int'({done, pass}), 3);
    end
    do_run(0, 0, 0, 0, 1'b1);
    do_run(1, 0, 3, 1, 1'b0);
    do_run(1, 0, 0, 1, 1'b0);
    do_run(1, 0, 7, 0, 1'b0);
    do_run(2, 0, 2, 0, 1'b0);
    do_run(2, 0, 5, 0, 1'b0);
    do_run(1, 16, 1, 0, 1'b0);
    do_run(1, 37, 5, 0, 1'b0);
    do_run(1, 63, 0, 1, 1'b0);
    do_run(3, 20, 0, 0, 1'b0);
    do_run(3, 0, 0, 0, 1'b0);
    for (int r = 0; r < 30; r++) begin
      int t;
      t = int'($urandom_range(3, 0));
      do_run(t, int'($urandom_range(DEPTH - 1, 0)),
             (t == 2) ? int'($urandom_range(AW - 1, 0)) : int'($urandom_range(7, 0)),
             int'($urandom_range(1, 0)), 1'b0);
    end
    chk(both_cnt == 0, "R9", "cycles with write and read together", both_cnt, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule